// File: doc/BRIEF.md
# Ring All-Gather Node Controller

One instance of this block sits in each core of a one-way ring of identical processing cores. Every node drives a 32-bit data word and a 2-bit control code to its downstream neighbour, and takes the same pair from its upstream neighbour. When a core is ready to exchange data it pulses `start`. The exchange then runs in three steps. First comes a barrier: each node sends a token that carries its own identity, and every node passes on the tokens of the others. When a node has counted as many tokens as there are nodes, including its own, the second step begins and the node streams its local words downstream. In the third step the node replays the received words that still have recipients further along the ring.

Received data words land in an external receive buffer at consecutive addresses. Local words come from an external memory through a read port with no latency. At the end, every node's buffer holds the words of every other node. They are ordered by ring distance, nearest upstream node first. The node count and the per-node word count are inputs. The ring has no back-pressure: a node moves at most one word per cycle on each link.

Top module: `ring_allgather_node`

## Requirements
- R1: `tx_ctl` carries 2'b00 for idle, 2'b01 for a data word in `tx_data`, and 2'b10 for a barrier token whose originating node ID is in `tx_data[NW-1:0]`. The code 2'b11 is never driven.
- R2: After reset, `tx_ctl` is idle and `done` is low.
- R3: After `start`, the node emits its own token exactly once. It does so in the first cycle in which it has no token to pass on.
- R4: A token from another node is re-sent unchanged one cycle after it arrives. A token carrying the node's own ID is absorbed. Each link therefore carries exactly `num_nodes` tokens per exchange.
- R5: No data word is sent before the node's token count, which includes its own token, equals `num_nodes`.
- R6: In the second step the node sends local words 0 to `num_words`-1 in address order, one per cycle.
- R7: Every data word that arrives is written to the receive buffer, at addresses 0, 1, 2 and so on, in arrival order.
- R8: In the third step the node forwards the first (`num_nodes`-2)×`num_words` stored words in order. It never reads a word before that word has been stored. Each link carries (`num_nodes`-1)×`num_words` data words per exchange.
- R9: At the end, a node's buffer holds all words of the node at ring distance 1, then all words of the node at distance 2, and so on up to distance `num_nodes`-1. Within each node's block the words keep their original order.
- R10: `done` rises only once forwarding is finished and (`num_nodes`-1)×`num_words` words have been received. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | NW | This node's position in the ring |
| num_nodes | input | NW | Number of nodes in the ring (at least 2) |
| num_words | input | PW | Local words per node (at least 1) |
| start | input | 1 | Pulse to enter the exchange |
| rx_data | input | DW | Data or token ID from upstream |
| rx_ctl | input | 2 | Control code from upstream |
| tx_data | output | DW | Data or token ID to downstream |
| tx_ctl | output | 2 | Control code to downstream |
| loc_addr | output | PW | Local word read address |
| loc_rdata | input | DW | Local word at `loc_addr` |
| buf_we | output | 1 | Receive buffer write strobe |
| buf_waddr | output | NW+PW | Receive buffer write address |
| buf_wdata | output | DW | Receive buffer write data |
| buf_raddr | output | NW+PW | Receive buffer read address |
| buf_rdata | input | DW | Receive buffer word at `buf_raddr` |
| done | output | 1 | Exchange complete |

## Verification
The bench closes a ring of four nodes with the default widths and runs three exchanges with 5, 1 and 8 words per node. With four nodes, every word makes three hops, so the third step has real forwarding work, and both the distance ordering and the read-behind-write limit are exercised. The start pulses are staggered, given in reversed order, and in one run issued all in the same cycle. This exposes tokens that arrive before their receiver has started, token forwarding that collides with a node's own emission, and the barrier that holds data back until the last node joins.

// File: rtl/ring_allgather_node.sv
module ring_allgather_node #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int PW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    node_id,
  input  logic [NW-1:0]    num_nodes,
  input  logic [PW-1:0]    num_words,
  input  logic             start,
  input  logic [DW-1:0]    rx_data,
  input  logic [1:0]       rx_ctl,
  output logic [DW-1:0]    tx_data,
  output logic [1:0]       tx_ctl,
  output logic [PW-1:0]    loc_addr,
  input  logic [DW-1:0]    loc_rdata,
  output logic             buf_we,
  output logic [NW+PW-1:0] buf_waddr,
  output logic [DW-1:0]    buf_wdata,
  output logic [NW+PW-1:0] buf_raddr,
  input  logic [DW-1:0]    buf_rdata,
  output logic             done
);
  localparam int AW = NW + PW;
  localparam logic [1:0] C_IDLE = 2'b00, C_DATA = 2'b01, C_TOK = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_SEND, S_FWD, S_FIN} st_t;

  st_t           st;
  logic [NW-1:0] cnt;
  logic          own_pend;
  logic [PW-1:0] lptr;
  logic [AW-1:0] rptr, wptr;

  wire rx_tok  = (rx_ctl == C_TOK);
  wire rx_dat  = (rx_ctl == C_DATA);
  wire fwd_tok = rx_tok && (rx_data[NW-1:0] != node_id);

  wire [AW-1:0] n_ext     = AW'(num_nodes);
  wire [AW-1:0] w_ext     = AW'(num_words);
  wire [AW-1:0] fwd_total = (n_ext - AW'(2)) * w_ext;
  wire [AW-1:0] rx_total  = (n_ext - AW'(1)) * w_ext;

  assign loc_addr  = lptr;
  assign buf_raddr = rptr;
  assign buf_we    = rx_dat;
  assign buf_waddr = wptr;
  assign buf_wdata = rx_data;
  assign done      = (st == S_FIN) && (wptr == rx_total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      own_pend <= 1'b0;
      lptr     <= '0;
      rptr     <= '0;
      wptr     <= '0;
      tx_ctl   <= C_IDLE;
      tx_data  <= '0;
    end else begin
      tx_ctl  <= C_IDLE;
      tx_data <= '0;
      if (rx_dat) wptr <= wptr + AW'(1);
      case (st)
        S_IDLE, S_SYNC: begin
          if (st == S_IDLE && start) begin
            own_pend <= 1'b1;
            st       <= S_SYNC;
          end
          if (fwd_tok) begin
            tx_ctl  <= C_TOK;
            tx_data <= rx_data;
            cnt     <= cnt + NW'(1);
          end else if (own_pend) begin
            tx_ctl   <= C_TOK;
            tx_data  <= DW'(node_id);
            own_pend <= 1'b0;
            cnt      <= cnt + NW'(1);
          end
          if (st == S_SYNC && !own_pend && cnt == num_nodes) begin
            st   <= S_SEND;
            lptr <= '0;
          end
        end
        S_SEND: begin
          tx_ctl  <= C_DATA;
          tx_data <= loc_rdata;
          lptr    <= lptr + PW'(1);
          if (lptr == num_words - PW'(1)) st <= S_FWD;
        end
        S_FWD: begin
          if (rptr == fwd_total) begin
            st <= S_FIN;
          end else if (rptr < wptr) begin
            tx_ctl  <= C_DATA;
            tx_data <= buf_rdata;
            rptr    <= rptr + AW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  p_ctl_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctl != 2'b11);

  p_tok_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_tok |=> (tx_ctl == C_TOK) && (tx_data == $past(rx_data)));

  p_own_absorbed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tok && !fwd_tok) |=> !((tx_ctl == C_TOK) && (tx_data[NW-1:0] == node_id)));

  p_barrier_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ctl == C_DATA) |-> (cnt == num_nodes));

  p_read_behind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rptr <= wptr);

  p_wr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (wptr < rx_total));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: tb/ring_allgather_node_test.sv
module ring_allgather_node_test;
  localparam int CLK_PERIOD = 10;
  localparam int NN = 4;
  localparam int DW = 32, NW = 4, PW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NN-1:0] start = '0;
  logic [NN-1:0] dn;
  logic [PW-1:0] wcnt = PW'(1);
  logic [DW-1:0] lk_d [NN];
  logic [1:0]    lk_c [NN];
  logic [PW-1:0] la [NN];
  logic [DW-1:0] lrd [NN];
  logic          bwe [NN];
  logic [NW+PW-1:0] bwa [NN], bra [NN];
  logic [DW-1:0] bwd [NN], brd [NN];
  logic [DW-1:0] lmem [NN][16];
  logic [DW-1:0] rbuf [NN][64];
  logic [DW-1:0] expq [NN][$];

  int checks = 0, errors = 0, cyc = 0;
  int tokc [NN], ownc [NN], datc [NN], rxc [NN];
  int last_start = 0, first_dat = -1;
  logic [NN-1:0] dn_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar k = 0; k < NN; k++) begin : g
    assign lrd[k] = lmem[k][la[k][3:0]];
    assign brd[k] = rbuf[k][bra[k][5:0]];
    ring_allgather_node #(.DW(DW), .NW(NW), .PW(PW)) uut (
      .clk(clk), .rst_n(rst_n), .node_id(NW'(k)), .num_nodes(NW'(NN)),
      .num_words(wcnt), .start(start[k]),
      .rx_data(lk_d[(k+NN-1)%NN]), .rx_ctl(lk_c[(k+NN-1)%NN]),
      .tx_data(lk_d[k]), .tx_ctl(lk_c[k]),
      .loc_addr(la[k]), .loc_rdata(lrd[k]),
      .buf_we(bwe[k]), .buf_waddr(bwa[k]), .buf_wdata(bwd[k]),
      .buf_raddr(bra[k]), .buf_rdata(brd[k]), .done(dn[k]));
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word(input int src, input int run, input int i);
    return {8'(src), 8'(run), 16'(i * 7 + 3)};
  endfunction

  // Monitor: scoreboard of buffer writes (R7, R9), link traffic counts.
  always @(negedge clk) begin
    for (int k = 0; k < NN; k++) begin
      if (bwe[k]) begin
        rbuf[k][bwa[k][5:0]] <= bwd[k];
        chk(bwa[k] == (NW+PW)'(rxc[k]), "R7 write address", bwa[k], rxc[k]);
        if (expq[k].size() == 0) chk(1'b0, "R9 unexpected word", bwd[k], 0);
        else begin
          logic [DW-1:0] e;
          e = expq[k].pop_front();
          chk(bwd[k] == e, "R9 word order", bwd[k], e);
        end
        rxc[k]++;
      end
      if (lk_c[k] == 2'b10) begin
        tokc[k]++;
        if (lk_d[k][NW-1:0] == NW'(k)) ownc[k]++;
      end
      if (lk_c[k] == 2'b01) begin
        datc[k]++;
        if (first_dat < 0) first_dat = cyc;
      end
      if (dn[k] && !dn_prev[k])
        chk(rxc[k] == (NN-1) * int'(wcnt), "R10 done after all words", rxc[k], (NN-1) * int'(wcnt));
      if (dn_prev[k] && !dn[k] && rst_n)
        chk(1'b0, "R10 done dropped", 0, 1);
    end
    dn_prev <= dn;
  end

  task automatic run(input int r, input int w, input int o0, input int o1,
                     input int o2, input int o3, input int gap);
    int ord [4];
    ord = '{o0, o1, o2, o3};
    rst_n = 1'b0;
    wcnt  = PW'(w);
    for (int k = 0; k < NN; k++) begin
      for (int i = 0; i < 16; i++) lmem[k][i] = word(k, r, i);
      expq[k].delete();
      for (int d = 1; d < NN; d++)
        for (int i = 0; i < w; i++) expq[k].push_back(word((k - d + NN) % NN, r, i));
      tokc[k] = 0; ownc[k] = 0; datc[k] = 0; rxc[k] = 0;
    end
    first_dat = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NN; k++)
      chk(lk_c[k] == 2'b00 && !dn[k], "R2 reset state", {lk_c[k], dn[k]}, 0);
    if (gap < 0) begin
      start = '1;
      last_start = cyc;
      @(negedge clk);
      start = '0;
    end else begin
      for (int s = 0; s < 4; s++) begin
        start[ord[s]] = 1'b1;
        last_start = cyc;
        @(negedge clk);
        start[ord[s]] = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    for (int t = 0; t < 3000; t++) begin
      if (&dn) break;
      @(negedge clk);
    end
    chk(&dn, "R10 watchdog: all nodes done", dn, {NN{1'b1}});
    chk(first_dat > last_start, "R5 no data before last start", first_dat, last_start);
    for (int k = 0; k < NN; k++) begin
      chk(ownc[k] == 1, "R3 own token once", ownc[k], 1);
      chk(tokc[k] == NN, "R4 tokens per link", tokc[k], NN);
      chk(datc[k] == (NN-1) * w, "R8 data words per link", datc[k], (NN-1) * w);
      chk(expq[k].size() == 0, "R9 all words received", expq[k].size(), 0);
      chk(rbuf[k][0] == word((k + NN - 1) % NN, r, 0), "R6 first word from neighbour",
          rbuf[k][0], word((k + NN - 1) % NN, r, 0));
    end
    repeat (4) @(negedge clk);
    chk(&dn, "R10 done held", dn, {NN{1'b1}});
  endtask

  initial begin
    run(0, 5, 2, 0, 3, 1, 3);
    run(1, 1, 0, 1, 2, 3, -1);
    run(2, 8, 3, 2, 1, 0, 6);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule